// File: doc/BRIEF.md
# Sync-Framed Serial Read Deserializer

This block sits in the read path of a disk drive, between the data separator and the controller's byte bus. It takes recovered serial data, one bit per read-clock strobe, and turns it into bytes. A read only starts when the controller requests it and the drive is on cylinder and not writing. The block then waits a fixed settle interval so the phase-locked read clock can lock. After that it hunts for the sync pattern 0x19. Once sync is found, every following group of eight bits goes into an output byte register, which drives the controller bus.

The bit counter is armed by the device command strobe. While that strobe is low the counter sits at zero. When the strobe is high the counter moves to one and stays there until sync is seen. It then counts each strobe and wraps from eight back to one as each byte completes. The sync byte itself is never handed to the controller.

Top module: `rd_deser`

## Requirements
- R1: `bus_oe` rises one clock after `read_req` is high while `on_cyl` is high and `wr_busy` is low. It falls one clock after any of these conditions stops holding.
- R2: While `rst_n` is low, `rx_byte` is 0x00 and `rx_vld`, `data_good` and `bus_oe` are all low.
- R3: During the first SETTLE_CYC clocks of a read (CLK_MHZ x SETTLE_US, 500 by default), no sync pattern is recognized. `data_good` stays low through that interval, and afterwards until a fresh sync pattern arrives.
- R4: After the settle interval, with the counter armed, `data_good` rises on the strobe that completes the bits 0001 1001 (MSB first, value 0x19) in the shift window. It stays high until the read ends.
- R5: The eight bits of the sync pattern never produce an `rx_vld` pulse, and they never change `rx_byte`.
- R6: After sync, each eighth strobe loads the completed byte into `rx_byte` and raises `rx_vld` for exactly one clock. The first bit received is the MSB. That same strobe also shifts in its own bit, and this does not corrupt the transferred byte.
- R7: While `dev_cmd` is low the bit counter is held at zero. In that state, even a sync pattern arriving after settle does not set `data_good`.
- R8: A window that differs from 0x19 in any bit does not set `data_good`.
- R9: When the read ends (request dropped, off cylinder, or writing), `data_good` clears and the settle interval starts over. A sync sent at once after the read restarts is not recognized.
- R10: `rx_byte` keeps its value in every clock that has no `rx_vld` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| sdata | input | 1 | Recovered serial data bit |
| rck_stb | input | 1 | One-clock pulse marking the read-clock trailing edge |
| read_req | input | 1 | Controller read request |
| dev_cmd | input | 1 | Device command strobe; arms the bit counter while high |
| on_cyl | input | 1 | Heads are on cylinder |
| wr_busy | input | 1 | Drive is writing |
| rx_byte | output | 8 | Byte register driven onto the controller bus |
| rx_vld | output | 1 | One-clock pulse when rx_byte is loaded |
| data_good | output | 1 | Sync found; byte framing active |
| bus_oe | output | 1 | Read gate: byte register drives the bus |

## Verification
A stuck or early settle timer shows up when a sync sent inside the first 500 clocks raises `data_good`. That is seen within one strobe of the pattern. A bit counter that is off by one, or that starts counting too soon, shows up as `rx_vld` on the wrong strobe or as a byte misaligned by one bit. This is visible at the first byte after sync. A shift window that is not cleared between reads, or a good flag that does not clear, shows up as `data_good` staying high a few clocks after the read ends, or as a sync accepted with no settle.

// File: rtl/rd_deser_pkg.sv
package rd_deser_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam logic [BYTE_W-1:0] SYNC_PAT = 8'h19;

  typedef logic [BYTE_W-1:0] byte_t;

  // Next contents of the shift window after one MSB-first shift.
  function automatic byte_t shift_in(input byte_t cur, input logic b);
    return {cur[BYTE_W-2:0], b};
  endfunction
endpackage

// File: rtl/rd_gate_ctl.sv
module rd_gate_ctl #(
  parameter int unsigned SETTLE_CYC = 500
) (
  input  logic clk,
  input  logic rst_n,
  input  logic read_req,
  input  logic on_cyl,
  input  logic wr_busy,
  output logic gate,
  output logic settled
);
  localparam int unsigned TW = $clog2(SETTLE_CYC + 1);
  localparam logic [TW-1:0] LAST = TW'(SETTLE_CYC - 1);

  logic          gate_d, gate_q;
  logic          set_d, set_q;
  logic [TW-1:0] tcnt_d, tcnt_q;
  logic          tcnt_en;

  always_comb begin
    gate_d  = read_req & on_cyl & ~wr_busy;
    tcnt_en = gate_q & ~set_q;
    tcnt_d  = tcnt_q;
    set_d   = set_q;
    if (!gate_q) begin
      tcnt_d = '0;
      set_d  = 1'b0;
    end else if (tcnt_en) begin
      tcnt_d = tcnt_q + 1'b1;
      if (tcnt_q == LAST) set_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gate_q <= 1'b0;
      set_q  <= 1'b0;
      tcnt_q <= '0;
    end else begin
      gate_q <= gate_d;
      set_q  <= set_d;
      tcnt_q <= tcnt_d;
    end
  end

  assign gate    = gate_q;
  assign settled = set_q;
endmodule

// File: rtl/rd_shifter.sv
module rd_shifter
  import rd_deser_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  gate,
  input  logic  stb,
  input  logic  sdata,
  output byte_t win
);
  byte_t win_d, win_q;

  always_comb begin
    win_d = win_q;
    if (!gate)     win_d = '0;
    else if (stb)  win_d = shift_in(win_q, sdata);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) win_q <= '0;
    else        win_q <= win_d;
  end

  assign win = win_q;
endmodule

// File: rtl/rd_framer.sv
module rd_framer
  import rd_deser_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  gate,
  input  logic  settled,
  input  logic  dev_cmd,
  input  logic  stb,
  input  logic  sdata,
  input  byte_t win,
  output byte_t rx_byte,
  output logic  rx_vld,
  output logic  data_good
);
  localparam int unsigned CW = $clog2(BYTE_W + 1);
  localparam logic [CW-1:0] ONE  = CW'(1);
  localparam logic [CW-1:0] FULL = CW'(BYTE_W);

  logic [CW-1:0] cnt_d, cnt_q;
  logic          good_d, good_q;
  byte_t         byte_d, byte_q;
  logic          vld_d, vld_q;
  byte_t         nxt;
  logic          armed, hit, xfer;

  always_comb begin
    nxt   = shift_in(win, sdata);
    armed = (cnt_q == ONE);
    hit   = stb & settled & ~good_q & armed & (nxt == SYNC_PAT);
    xfer  = stb & good_q & (cnt_q == FULL);

    cnt_d  = cnt_q;
    good_d = good_q;
    byte_d = byte_q;
    vld_d  = 1'b0;

    if (!gate || !dev_cmd) begin
      cnt_d = '0;
    end else if (cnt_q == '0) begin
      cnt_d = ONE;
    end else if (stb && good_q) begin
      cnt_d = xfer ? ONE : cnt_q + 1'b1;
    end

    if (!gate)     good_d = 1'b0;
    else if (hit)  good_d = 1'b1;

    if (xfer && gate && dev_cmd) begin
      byte_d = nxt;
      vld_d  = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      good_q <= 1'b0;
      byte_q <= '0;
      vld_q  <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      good_q <= good_d;
      byte_q <= byte_d;
      vld_q  <= vld_d;
    end
  end

  assign rx_byte   = byte_q;
  assign rx_vld    = vld_q;
  assign data_good = good_q;
endmodule

// File: rtl/rd_deser.sv
module rd_deser #(
  parameter int unsigned CLK_MHZ   = 100,
  parameter int unsigned SETTLE_US = 5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sdata,
  input  logic       rck_stb,
  input  logic       read_req,
  input  logic       dev_cmd,
  input  logic       on_cyl,
  input  logic       wr_busy,
  output logic [7:0] rx_byte,
  output logic       rx_vld,
  output logic       data_good,
  output logic       bus_oe
);
  import rd_deser_pkg::*;
  localparam int unsigned SETTLE_CYC = CLK_MHZ * SETTLE_US;

  logic  gate, settled;
  byte_t win;

  rd_gate_ctl #(.SETTLE_CYC(SETTLE_CYC)) u_gate (
    .clk(clk), .rst_n(rst_n), .read_req(read_req), .on_cyl(on_cyl),
    .wr_busy(wr_busy), .gate(gate), .settled(settled)
  );

  rd_shifter u_shift (
    .clk(clk), .rst_n(rst_n), .gate(gate), .stb(rck_stb),
    .sdata(sdata), .win(win)
  );

  rd_framer u_frame (
    .clk(clk), .rst_n(rst_n), .gate(gate), .settled(settled),
    .dev_cmd(dev_cmd), .stb(rck_stb), .sdata(sdata), .win(win),
    .rx_byte(rx_byte), .rx_vld(rx_vld), .data_good(data_good)
  );

  assign bus_oe = gate;
endmodule

// File: rtl/rd_deser_chk.sv
module rd_deser_chk #(
  parameter int unsigned SETTLE_CYC = 500
) (
  input logic       clk,
  input logic       rst_n,
  input logic       read_req,
  input logic       on_cyl,
  input logic       wr_busy,
  input logic [7:0] rx_byte,
  input logic       rx_vld,
  input logic       data_good,
  input logic       bus_oe
);
  localparam int unsigned GW = $clog2(SETTLE_CYC + 2);

  logic          past_ok;
  logic [GW-1:0] gcnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      past_ok <= 1'b0;
      gcnt    <= '0;
    end else begin
      past_ok <= 1'b1;
      if (!bus_oe)                         gcnt <= '0;
      else if (gcnt != GW'(SETTLE_CYC + 1)) gcnt <= gcnt + 1'b1;
    end
  end

  // R1
  gate_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok |-> (bus_oe == $past(read_req & on_cyl & ~wr_busy)));

  // R3
  settle_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(data_good) |-> (gcnt > GW'(SETTLE_CYC)));

  // R9
  good_needs_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && !$past(bus_oe)) |-> !data_good);

  // R6
  vld_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_vld |=> !rx_vld);

  // R5
  vld_after_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_vld |-> (data_good && $past(data_good)));

  // R10
  byte_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && !rx_vld) |-> (rx_byte == $past(rx_byte)));
endmodule

bind rd_deser rd_deser_chk #(.SETTLE_CYC(SETTLE_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .read_req(read_req), .on_cyl(on_cyl),
  .wr_busy(wr_busy), .rx_byte(rx_byte), .rx_vld(rx_vld),
  .data_good(data_good), .bus_oe(bus_oe)
);

// File: tb/rd_deser_test.sv
module rd_deser_test;
  logic       clk, rst_n, sdata, rck_stb, read_req, dev_cmd, on_cyl, wr_busy;
  logic [7:0] rx_byte;
  logic       rx_vld, data_good, bus_oe;
  int total = 0;
  int bad   = 0;

  rd_deser uut (
    .clk(clk), .rst_n(rst_n), .sdata(sdata), .rck_stb(rck_stb),
    .read_req(read_req), .dev_cmd(dev_cmd), .on_cyl(on_cyl),
    .wr_busy(wr_busy), .rx_byte(rx_byte), .rx_vld(rx_vld),
    .data_good(data_good), .bus_oe(bus_oe)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bit(input logic b, output logic vld);
    @(negedge clk); sdata = b; rck_stb = 1'b1;
    @(negedge clk); rck_stb = 1'b0; vld = rx_vld;
    idle(2);
  endtask

  // vmask bit i holds rx_vld seen after sending data bit i (MSB first)
  task automatic send_byte(input logic [7:0] v, output logic [7:0] vmask);
    for (int i = 7; i >= 0; i--) begin
      logic vb;
      send_bit(v[i], vb);
      vmask[i] = vb;
    end
  endtask

  task automatic begin_read(input logic cmd);
    @(negedge clk);
    read_req = 1'b1; on_cyl = 1'b1; wr_busy = 1'b0; dev_cmd = cmd;
  endtask

  task automatic end_read();
    @(negedge clk);
    read_req = 1'b0; dev_cmd = 1'b0;
    idle(3);
  endtask

  task automatic t_reset();
    chk("R2 rx_byte", rx_byte, 8'h00);
    chk("R2 rx_vld", {7'b0, rx_vld}, 8'h00);
    chk("R2 data_good", {7'b0, data_good}, 8'h00);
    chk("R2 bus_oe", {7'b0, bus_oe}, 8'h00);
  endtask

  task automatic t_gate();
    @(negedge clk); read_req = 1'b1; on_cyl = 1'b1; wr_busy = 1'b0;
    chk("R1 oe before edge", {7'b0, bus_oe}, 8'h00);
    @(negedge clk);
    chk("R1 oe one clock later", {7'b0, bus_oe}, 8'h01);
    wr_busy = 1'b1;
    @(negedge clk);
    chk("R1 oe off while writing", {7'b0, bus_oe}, 8'h00);
    wr_busy = 1'b0; on_cyl = 1'b0;
    @(negedge clk);
    chk("R1 oe off cylinder", {7'b0, bus_oe}, 8'h00);
    end_read();
  endtask

  task automatic t_early_sync();
    logic [7:0] m;
    begin_read(1'b1);
    idle(4);
    send_byte(8'h19, m);
    chk("R3 sync inside settle ignored", {7'b0, data_good}, 8'h00);
    idle(520);
    chk("R3 still low after settle", {7'b0, data_good}, 8'h00);
    send_byte(8'h00, m);
    chk("R3 zeros after settle", {7'b0, data_good}, 8'h00);
    end_read();
  endtask

  task automatic t_frame();
    logic [7:0] m;
    logic [7:0] held;
    begin_read(1'b1);
    idle(520);
    send_byte(8'h00, m);
    held = rx_byte;
    send_byte(8'h19, m);
    chk("R4 data_good after sync", {7'b0, data_good}, 8'h01);
    chk("R5 no vld during sync", m, 8'h00);
    chk("R5 byte unchanged by sync", rx_byte, held);
    send_byte(8'hA5, m);
    chk("R6 first byte", rx_byte, 8'hA5);
    chk("R6 vld only on bit eight", m, 8'h01);
    send_byte(8'h3C, m);
    chk("R6 second byte", rx_byte, 8'h3C);
    chk("R6 second vld", m, 8'h01);
    send_byte(8'h19, m);
    chk("R6 sync value passes as data", rx_byte, 8'h19);
    idle(30);
    chk("R10 byte holds while idle", rx_byte, 8'h19);
    chk("R4 data_good sticky", {7'b0, data_good}, 8'h01);
    end_read();
    chk("R9 data_good clears", {7'b0, data_good}, 8'h00);
  endtask

  task automatic t_near_miss();
    logic [7:0] m;
    begin_read(1'b1);
    idle(520);
    send_byte(8'h18, m);
    send_byte(8'h09, m);
    send_byte(8'h38, m);
    send_byte(8'h1B, m);
    chk("R8 near patterns rejected", {7'b0, data_good}, 8'h00);
    end_read();
  endtask

  task automatic t_cmd_low();
    logic [7:0] m;
    begin_read(1'b0);
    idle(520);
    send_byte(8'h19, m);
    chk("R7 no sync while counter held", {7'b0, data_good}, 8'h00);
    @(negedge clk); dev_cmd = 1'b1;
    idle(2);
    send_byte(8'h19, m);
    chk("R7 sync once armed", {7'b0, data_good}, 8'h01);
    send_byte(8'hC3, m);
    chk("R7 byte after arming", rx_byte, 8'hC3);
  endtask

  task automatic t_drop();
    logic [7:0] m;
    @(negedge clk); on_cyl = 1'b0;
    idle(3);
    chk("R9 oe off after leaving cylinder", {7'b0, bus_oe}, 8'h00);
    chk("R9 good cleared", {7'b0, data_good}, 8'h00);
    @(negedge clk); on_cyl = 1'b1;
    idle(2);
    send_byte(8'h19, m);
    chk("R9 settle restarts", {7'b0, data_good}, 8'h00);
    end_read();
  endtask

  initial begin
    rst_n = 1'b0; sdata = 1'b0; rck_stb = 1'b0; read_req = 1'b0;
    dev_cmd = 1'b0; on_cyl = 1'b0; wr_busy = 1'b0;
    idle(3);
    t_reset();
    @(negedge clk); rst_n = 1'b1;
    idle(2);
    t_gate();
    t_early_sync();
    t_frame();
    t_near_miss();
    t_cmd_low();
    t_drop();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule